// File: doc/BRIEF.md
# Bus Fault Trip Supervisor

This block is the decision stage of a fast trip scheme for a distribution bus. Several protection units, one per feeder or source breaker on the bus, each report whether the fault they see lies toward the bus or away from it. The supervisor issues a trip only when every unit agrees that the fault sits inside the bus zone. It also stretches the trip into a pulse of guaranteed width. Each unit sends six flags: a fault toward the bus, a fault away from the bus, a healthy channel, a loss of potential, an out-of-service state, and a closed breaker.

Any unit that sees an away-from-bus fault for long enough arms a transient-reversal block. This block holds for a fixed time after the external indication goes away, so a fault whose direction flips back and forth cannot produce a false trip. A loss of potential or an out-of-service state at any unit disables the trip function altogether. All delays are given in milliseconds and turned into clock cycles by a cycles-per-millisecond parameter.

Top module: `bus_trip_supervisor`

## Requirements
- R1: A unit qualifies as internal when its breaker is open, or when it reports toward-bus with a healthy channel and no away-from-bus flag. `trip_o` can assert only when all units qualify. Any other combination of toward flags gives no trip.
- R2: When all units qualify continuously, with no block and no disable, `trip_o` rises exactly TRIP_PU_MS*TICKS_PER_MS+1 cycles after the condition appears. With the defaults this is 81 cycles, or 20.25 ms, which is under 25 ms.
- R3: After the last cycle in which the trip pickup is complete, `trip_o` stays high for TRIP_MIN_MS*TICKS_PER_MS cycles. It stays high for as long as the pickup remains complete.
- R4: An external indication from a unit means away-from-bus with a healthy channel and a closed breaker. If any unit holds one for EXT_PU_MS*TICKS_PER_MS cycles, `blocked_o` rises after that many cycles. A shorter indication arms nothing.
- R5: Once armed, `blocked_o` stays high for TRB_HOLD_MS*TICKS_PER_MS cycles after the external indication ends. No trip pickup progresses while `blocked_o` is high, and the pickup starts from zero when the block clears.
- R6: Alternating all-internal for about 2 power cycles (132 clock cycles) with one unit external for about 4 power cycles (268 clock cycles), starting with the external phase, never produces a trip.
- R7: A loss-of-potential or out-of-service flag at any unit raises `disabled_o` one cycle later. While the flag is present, an all-internal condition gives no trip.
- R8: A unit with an unhealthy channel does not qualify as internal, even when it reports toward-bus.
- R9: A unit with an open breaker qualifies as internal, and its away-from-bus flag is ignored. The remaining units can still trip the bus.
- R10: After synchronous reset, `trip_o`, `blocked_o` and `disabled_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_toward_i | input | N_UNITS | Per unit: fault seen toward the bus |
| fault_away_i | input | N_UNITS | Per unit: fault seen away from the bus |
| chan_ok_i | input | N_UNITS | Per unit: communication channel healthy |
| lop_i | input | N_UNITS | Per unit: loss of potential |
| oos_i | input | N_UNITS | Per unit: unit out of service |
| brk_closed_i | input | N_UNITS | Per unit: breaker closed |
| trip_o | output | 1 | Stretched bus trip pulse |
| blocked_o | output | 1 | Transient-reversal block active |
| disabled_o | output | 1 | Fast trip disabled by any unit |

## Verification
Each output has its own fixed latency from a change at the inputs. `disabled_o` follows one cycle later. `blocked_o` rises exactly the external pickup count after the external indication starts, and falls the hold count plus one cycle after it ends. `trip_o` rises the trip pickup count plus one cycle after a qualified all-internal condition starts, and a block or a disable adds its own clearance time in front of that. Inputs are driven at the falling edge, and each result is sampled at falling edges placed one cycle before and exactly at the computed rising or falling edge. This pins every delay to a single cycle. The sweeps cover every toward pattern and every per-unit disable, channel and breaker case, and each stimulus ends with a settle period longer than the block hold plus the trip pulse.

// File: rtl/bts_pkg.sv
`timescale 1ns/1ps
package bts_pkg;

    typedef struct packed {
        logic toward;
        logic away;
        logic chan_ok;
        logic lop;
        logic oos;
        logic brk_closed;
    } unit_in_t;

    typedef struct packed {
        logic internal_ok;
        logic external;
        logic inhibit;
    } unit_vote_t;

    function automatic int unsigned ms_to_ticks(input int unsigned ms, input int unsigned tpm);
        return ms * tpm;
    endfunction

endpackage

// File: rtl/bts_unit_vote.sv
`timescale 1ns/1ps
module bts_unit_vote
    import bts_pkg::*;
(
    input  unit_in_t   in_i,
    output unit_vote_t vote_o
);
    always_comb begin
        // an open breaker carries no fault current, so it never vetoes
        vote_o.internal_ok = !in_i.brk_closed
                           | (in_i.toward & in_i.chan_ok & !in_i.away);
        vote_o.external    = in_i.brk_closed & in_i.chan_ok & in_i.away;
        vote_o.inhibit     = in_i.lop | in_i.oos;
    end
endmodule

// File: rtl/bts_pickup_timer.sv
`timescale 1ns/1ps
module bts_pickup_timer #(
    parameter int unsigned LIMIT    = 64,
    parameter bit          GATE_OUT = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic done_o
);
    localparam int unsigned W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM_V = W'(LIMIT);

    logic [W-1:0] cnt_q;
    logic         reached;

    always_ff @(posedge clk) begin
        if (rst)             cnt_q <= '0;
        else if (!run_i)     cnt_q <= '0;
        else if (!reached)   cnt_q <= cnt_q + 1'b1;
    end

    assign reached = (cnt_q == LIM_V);

    generate
        if (GATE_OUT) begin : g_gated
            assign done_o = reached & run_i;
        end else begin : g_plain
            assign done_o = reached;
        end
    endgenerate
endmodule

// File: rtl/bts_hold_timer.sv
`timescale 1ns/1ps
module bts_hold_timer #(
    parameter int unsigned HOLD = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic active_o
);
    localparam int unsigned W = $clog2(HOLD + 1);
    localparam logic [W-1:0] HOLD_V = W'(HOLD);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load_i)        cnt_q <= HOLD_V;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign active_o = (cnt_q != '0);
endmodule

// File: rtl/bus_trip_supervisor.sv
`timescale 1ns/1ps
module bus_trip_supervisor
    import bts_pkg::*;
#(
    parameter int unsigned N_UNITS      = 3,
    parameter int unsigned TICKS_PER_MS = 4,
    parameter int unsigned TRIP_PU_MS   = 20,
    parameter int unsigned EXT_PU_MS    = 16,
    parameter int unsigned TRB_HOLD_MS  = 160,
    parameter int unsigned TRIP_MIN_MS  = 100
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_UNITS-1:0] fault_toward_i,
    input  logic [N_UNITS-1:0] fault_away_i,
    input  logic [N_UNITS-1:0] chan_ok_i,
    input  logic [N_UNITS-1:0] lop_i,
    input  logic [N_UNITS-1:0] oos_i,
    input  logic [N_UNITS-1:0] brk_closed_i,
    output logic               trip_o,
    output logic               blocked_o,
    output logic               disabled_o
);
    localparam int unsigned TRIP_PU_T = ms_to_ticks(TRIP_PU_MS, TICKS_PER_MS);
    localparam int unsigned EXT_PU_T  = ms_to_ticks(EXT_PU_MS, TICKS_PER_MS);
    localparam int unsigned HOLD_T    = ms_to_ticks(TRB_HOLD_MS, TICKS_PER_MS);
    localparam int unsigned MIN_T     = ms_to_ticks(TRIP_MIN_MS, TICKS_PER_MS);

    unit_in_t   unit_in [N_UNITS];
    unit_vote_t vote    [N_UNITS];

    genvar u;
    generate
        for (u = 0; u < N_UNITS; u++) begin : g_unit
            assign unit_in[u] = '{toward:     fault_toward_i[u],
                                  away:       fault_away_i[u],
                                  chan_ok:    chan_ok_i[u],
                                  lop:        lop_i[u],
                                  oos:        oos_i[u],
                                  brk_closed: brk_closed_i[u]};
            bts_unit_vote vote_i (
                .in_i   (unit_in[u]),
                .vote_o (vote[u])
            );
        end
    endgenerate

    logic all_internal, any_external, any_inhibit;

    always_comb begin
        all_internal = 1'b1;
        any_external = 1'b0;
        any_inhibit  = 1'b0;
        for (int i = 0; i < N_UNITS; i++) begin
            all_internal = all_internal & vote[i].internal_ok;
            any_external = any_external | vote[i].external;
            any_inhibit  = any_inhibit  | vote[i].inhibit;
        end
    end

    // transient-reversal block: pickup on external, then stretched hold
    logic ext_armed, blk_hold, blocked;

    bts_pickup_timer #(.LIMIT(EXT_PU_T), .GATE_OUT(1'b0)) ext_pu_i (
        .clk    (clk),
        .rst    (rst),
        .run_i  (any_external),
        .done_o (ext_armed)
    );

    bts_hold_timer #(.HOLD(HOLD_T)) blk_hold_i (
        .clk      (clk),
        .rst      (rst),
        .load_i   (ext_armed),
        .active_o (blk_hold)
    );

    assign blocked = ext_armed | blk_hold;

    // trip path: qualified all-internal pickup, then minimum-width stretch
    logic qualify, trip_fire;

    assign qualify = all_internal & !any_external & !blocked & !any_inhibit;

    bts_pickup_timer #(.LIMIT(TRIP_PU_T), .GATE_OUT(1'b1)) trip_pu_i (
        .clk    (clk),
        .rst    (rst),
        .run_i  (qualify),
        .done_o (trip_fire)
    );

    bts_hold_timer #(.HOLD(MIN_T)) trip_hold_i (
        .clk      (clk),
        .rst      (rst),
        .load_i   (trip_fire),
        .active_o (trip_o)
    );

    logic disabled_q;
    always_ff @(posedge clk) begin
        if (rst) disabled_q <= 1'b0;
        else     disabled_q <= any_inhibit;
    end

    assign disabled_o = disabled_q;
    assign blocked_o  = blocked;
endmodule

// File: rtl/bts_checker.sv
`timescale 1ns/1ps
module bts_checker #(
    parameter int unsigned N_UNITS = 3,
    parameter int unsigned MIN_CYC = 400
) (
    input logic               clk,
    input logic               rst,
    input logic [N_UNITS-1:0] fault_toward_i,
    input logic [N_UNITS-1:0] fault_away_i,
    input logic [N_UNITS-1:0] chan_ok_i,
    input logic [N_UNITS-1:0] lop_i,
    input logic [N_UNITS-1:0] oos_i,
    input logic [N_UNITS-1:0] brk_closed_i,
    input logic               trip_o,
    input logic               blocked_o,
    input logic               disabled_o
);
    localparam int unsigned LW = $clog2(MIN_CYC + 2);

    logic all_ok, any_inh;
    assign all_ok  = &(~brk_closed_i | (fault_toward_i & chan_ok_i & ~fault_away_i));
    assign any_inh = |(lop_i | oos_i);

    logic [LW-1:0] hi_len;
    always_ff @(posedge clk) begin
        if (rst)                              hi_len <= '0;
        else if (!trip_o)                     hi_len <= '0;
        else if (hi_len != LW'(MIN_CYC))      hi_len <= hi_len + 1'b1;
    end

    p_trip_quorum_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(trip_o) |-> $past(all_ok));

    p_trip_min_width_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(trip_o) |-> (hi_len >= LW'(MIN_CYC)));

    p_no_trip_under_block_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(trip_o) |-> !$past(blocked_o));

    p_no_trip_disabled_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(trip_o) |-> !$past(any_inh));

    p_disable_rise_r7: assert property (@(posedge clk) disable iff (rst)
        any_inh |=> disabled_o);

    p_disable_clear_r7: assert property (@(posedge clk) disable iff (rst)
        !any_inh |=> !disabled_o);
endmodule

bind bus_trip_supervisor bts_checker #(
    .N_UNITS (N_UNITS),
    .MIN_CYC (TRIP_MIN_MS * TICKS_PER_MS)
) chk_i (
    .clk            (clk),
    .rst            (rst),
    .fault_toward_i (fault_toward_i),
    .fault_away_i   (fault_away_i),
    .chan_ok_i      (chan_ok_i),
    .lop_i          (lop_i),
    .oos_i          (oos_i),
    .brk_closed_i   (brk_closed_i),
    .trip_o         (trip_o),
    .blocked_o      (blocked_o),
    .disabled_o     (disabled_o)
);

// File: tb/bus_trip_supervisor_tb_top.sv
`timescale 1ns/1ps
module bus_trip_supervisor_tb_top;
    localparam int LIM = 20 * 4;   // trip pickup cycles
    localparam int EPU = 16 * 4;   // external pickup cycles
    localparam int HLD = 160 * 4;  // block hold cycles
    localparam int MIN = 100 * 4;  // trip minimum width cycles

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] tow, awy, chn, lop, oos, brk;
    logic trip_o, blocked_o, disabled_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    bus_trip_supervisor dut_i (
        .clk(clk), .rst(rst),
        .fault_toward_i(tow), .fault_away_i(awy), .chan_ok_i(chn),
        .lop_i(lop), .oos_i(oos), .brk_closed_i(brk),
        .trip_o(trip_o), .blocked_o(blocked_o), .disabled_o(disabled_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input logic [2:0] t, a, c, l, o, b);
        tow = t; awy = a; chn = c; lop = l; oos = o; brk = b;
    endtask

    task automatic idle();
        drive(3'b000, 3'b000, 3'b111, 3'b000, 3'b000, 3'b111);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        idle();
        step(HLD + MIN + 10);
    endtask

    initial begin
        idle();
        step(4);
        rst = 1'b0;
        step(1);
        // R10 reset state
        chk(trip_o == 0, "R10 trip", trip_o, 0);
        chk(blocked_o == 0, "R10 blocked", blocked_o, 0);
        chk(disabled_o == 0, "R10 disabled", disabled_o, 0);

        // R1/R2/R3 sweep over every toward pattern
        for (int m = 0; m < 8; m++) begin
            drive(3'(m), 3'b000, 3'b111, 3'b000, 3'b000, 3'b111);
            step(LIM);
            chk(trip_o == 0, "R2 before pickup", trip_o, 0);
            step(1);
            chk(trip_o == (m == 7), "R1 quorum", trip_o, (m == 7));
            if (m == 7) begin
                step(50);
                chk(trip_o == 1, "R3 held while qualified", trip_o, 1);
                idle();
                step(MIN - 1);
                chk(trip_o == 1, "R3 min width", trip_o, 1);
                step(1);
                chk(trip_o == 0, "R3 release", trip_o, 0);
            end
            settle();
        end

        // R4 short external indication arms nothing
        drive(3'b000, 3'b001, 3'b111, 3'b000, 3'b000, 3'b111);
        step(EPU - 1);
        chk(blocked_o == 0, "R4 short external", blocked_o, 0);
        drive(3'b111, 3'b000, 3'b111, 3'b000, 3'b000, 3'b111);
        step(LIM + 1);
        chk(trip_o == 1, "R4 no block after short external", trip_o, 1);
        settle();

        // R4/R5 external held exactly for pickup time
        drive(3'b000, 3'b001, 3'b111, 3'b000, 3'b000, 3'b111);
        step(EPU - 1);
        chk(blocked_o == 0, "R4 before pickup", blocked_o, 0);
        step(1);
        chk(blocked_o == 1, "R4 armed", blocked_o, 1);
        drive(3'b111, 3'b000, 3'b111, 3'b000, 3'b000, 3'b111);
        step(HLD);
        chk(blocked_o == 1, "R5 hold", blocked_o, 1);
        chk(trip_o == 0, "R5 suppressed", trip_o, 0);
        step(1);
        chk(blocked_o == 0, "R5 hold end", blocked_o, 0);
        step(LIM);
        chk(trip_o == 0, "R5 pickup restarts", trip_o, 0);
        step(1);
        chk(trip_o == 1, "R5 trip after clear", trip_o, 1);
        settle();

        // R1 one unit external, others internal
        for (int u = 0; u < 3; u++) begin
            drive(~(3'b001 << u), 3'b001 << u, 3'b111, 3'b000, 3'b000, 3'b111);
            step(LIM + EPU + 5);
            chk(trip_o == 0, "R1 one external", trip_o, 0);
            settle();
        end

        // R7 disable by lop then oos at each unit
        for (int u = 0; u < 3; u++) begin
            for (int k = 0; k < 2; k++) begin
                if (k == 0) drive(3'b111, 3'b000, 3'b111, 3'b001 << u, 3'b000, 3'b111);
                else        drive(3'b111, 3'b000, 3'b111, 3'b000, 3'b001 << u, 3'b111);
                step(1);
                chk(disabled_o == 1, "R7 disabled flag", disabled_o, 1);
                step(LIM + 10);
                chk(trip_o == 0, "R7 no trip while disabled", trip_o, 0);
                idle();
                step(1);
                chk(disabled_o == 0, "R7 flag clears", disabled_o, 0);
                settle();
            end
        end

        // R8 unhealthy channel at each unit
        for (int u = 0; u < 3; u++) begin
            drive(3'b111, 3'b000, ~(3'b001 << u), 3'b000, 3'b000, 3'b111);
            step(LIM + 10);
            chk(trip_o == 0, "R8 bad channel", trip_o, 0);
            settle();
        end

        // R9 open breaker: satisfied, away flag ignored
        for (int u = 0; u < 3; u++) begin
            drive(~(3'b001 << u), 3'b001 << u, 3'b111, 3'b000, 3'b000, ~(3'b001 << u));
            step(LIM);
            chk(trip_o == 0, "R9 before pickup", trip_o, 0);
            chk(blocked_o == 0, "R9 away ignored", blocked_o, 0);
            step(1);
            chk(trip_o == 1, "R9 open breaker trip", trip_o, 1);
            settle();
        end

        // R6 transient reversal alternation
        begin
            bit seen = 0;
            for (int r = 0; r < 5; r++) begin
                drive(3'b101, 3'b010, 3'b111, 3'b000, 3'b000, 3'b111);
                for (int c = 0; c < 268; c++) begin step(1); if (trip_o) seen = 1; end
                drive(3'b111, 3'b000, 3'b111, 3'b000, 3'b000, 3'b111);
                for (int c = 0; c < 132; c++) begin step(1); if (trip_o) seen = 1; end
            end
            chk(seen == 0, "R6 reversal no trip", seen, 0);
            settle();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        finished = 1;
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule